// File: doc/BRIEF.md
# Addressable Bit Register with Demultiplexer Mode

This block holds a row of single-bit storage cells, eight by default, that are written one at a time. A binary address picks one cell, and on a rising clock edge the value on the serial data input is stored into that cell, provided writing is enabled. The whole row is always visible on a parallel output bus, so software-free control logic can set or clear individual flags, and later read all of them at once.

An active-low synchronous clear empties the register. When the clear is asserted while writing is still enabled, the block switches to demultiplexer mode. In that mode the addressed output takes the data input and every other output is forced to zero. This gives a one-of-N router from a single data line.

Top module: `addr_bit_register`

## Requirements
- R1: When `clr_n` is 0 and `wr_dis` is 1 at a rising clock edge, every bit of `q` is 0 after that edge.
- R2: When `clr_n` is 1 and `wr_dis` is 0 at a rising clock edge, bit `q[addr]` takes the value of `din` after that edge.
- R3: When `clr_n` is 1 and `wr_dis` is 1 at a rising clock edge, `q` is unchanged after that edge, whatever `addr` and `din` are.
- R4: When `clr_n` is 0 and `wr_dis` is 0 at a rising clock edge (demultiplexer mode), `q[addr]` equals `din` after that edge and all other bits are 0.
- R5: During a write (R2), the bits not selected by `addr` keep their stored values.
- R6: `addr` is an unsigned binary index with bit 0 as its least significant bit, so the value n selects `q[n]` for every n from 0 to 7.
- R7: After demultiplexer mode ends with `wr_dis` high and `clr_n` high, `q` keeps the one-hot or all-zero pattern the last demultiplexer cycle left in it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous master clear, active low |
| wr_dis | input | 1 | Write disable, active high |
| addr | input | 3 | Index of the bit to write |
| din | input | 1 | Serial data input |
| q | output | 8 | Stored bits, always readable |

## Verification
The assertions check on every cycle that each of the four control combinations leaves the register in the state its requirement demands: a full clear, a stored addressed bit, an unchanged register, or a demultiplexer pattern with at most one bit set at the addressed position. They can't show that a given address reaches the intended physical output as a whole pattern over time. The bench's sweeps over every address and both data values against an arithmetic model cover that, along with the preservation of untouched bits across long write sequences and the pattern that survives when demultiplexer mode ends.

// File: rtl/addr_bit_register_pkg.sv
// Package: shared types for the addressable bit register.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package addr_bit_register_pkg;

    // Operating mode derived from the clear and write-disable inputs.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_DEMUX = 2'b11
    } mode_e;

    // Map the two control levels onto a mode.
    function automatic mode_e decode_mode(input logic clr_n, input logic wr_dis);
        if (clr_n) begin
            return wr_dis ? MODE_HOLD : MODE_WRITE;
        end
        return wr_dis ? MODE_CLEAR : MODE_DEMUX;
    endfunction

endpackage

// File: rtl/abr_addr_decode.sv
// Module: one-hot address decoder.
// Turns a binary index into a one-hot select vector, with bit 0 of the
// index as its least significant bit. Assumes NBITS <= 2**ADDR_W.
module abr_addr_decode #(
    parameter int NBITS  = 8,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NBITS-1:0]  sel
);

    // One comparator per output bit.
    for (genvar i = 0; i < NBITS; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end

    // R6: the select vector has at most one bit set.
    always_comb begin
        a_sel_onehot_r6: assert ($onehot0(sel) || $isunknown(addr))
            else $error("decoder produced more than one select");
    end

endmodule

// File: rtl/abr_mode_ctrl.sv
// Module: mode controller.
// Combines the active-low clear and active-high write disable into one
// mode value shared by all cells. Purely combinational.
module abr_mode_ctrl
    import addr_bit_register_pkg::*;
(
    input  logic  clr_n,
    input  logic  wr_dis,
    output mode_e mode
);

    // Decode the current control levels.
    always_comb mode = decode_mode(clr_n, wr_dis);

endmodule

// File: rtl/abr_bit_cell.sv
// Module: single storage bit.
// Updates on the rising clock edge according to the shared mode and its
// own select line. Assumes mode and sel are stable around the edge.
module abr_bit_cell
    import addr_bit_register_pkg::*;
(
    input  logic  clk,
    input  mode_e mode,
    input  logic  sel,
    input  logic  din,
    output logic  q
);

    // Next state for this bit, by mode.
    always_ff @(posedge clk) begin
        unique case (mode)
            MODE_WRITE: if (sel) q <= din;
            MODE_DEMUX: q <= sel & din;
            MODE_CLEAR: q <= 1'b0;
            default:    q <= q;
        endcase
    end

    // R3 / R5: an unselected bit in write mode, or any bit in hold mode, keeps its value.
    p_keep_r5: assert property (@(posedge clk)
        ((mode == MODE_HOLD) || (mode == MODE_WRITE && !sel)) |=> $stable(q))
        else $error("cell changed while it should hold");

endmodule

// File: rtl/addr_bit_register.sv
// Module: addressable bit register (top).
// A row of NBITS cells written one at a time through a decoded address.
// There is an active-low synchronous clear, and a demultiplexer mode when
// clear and write are both active. Assumes synchronous inputs.
module addr_bit_register
    import addr_bit_register_pkg::*;
#(
    parameter int NBITS = 8,
    localparam int ADDR_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              wr_dis,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [NBITS-1:0]  q
);

    mode_e            mode;
    logic [NBITS-1:0] sel;

    abr_mode_ctrl u_mode (
        .clr_n  (clr_n),
        .wr_dis (wr_dis),
        .mode   (mode)
    );

    abr_addr_decode #(.NBITS(NBITS), .ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    // One storage cell per output bit.
    for (genvar i = 0; i < NBITS; i++) begin : g_cell
        abr_bit_cell u_cell (
            .clk  (clk),
            .mode (mode),
            .sel  (sel[i]),
            .din  (din),
            .q    (q[i])
        );
    end

    // R1: clear with writing disabled empties the register.
    p_clear_r1: assert property (@(posedge clk)
        (!clr_n && wr_dis) |=> (q == '0))
        else $error("clear left bits set");

    // R2: a write stores din into the addressed bit.
    p_write_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (!wr_dis) |=> (q[$past(addr)] == $past(din)))
        else $error("write did not store data");

    // R3: hold mode leaves the whole register unchanged.
    p_hold_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (wr_dis) |=> $stable(q))
        else $error("register changed while writing disabled");

    // R4: demultiplexer mode routes din to the addressed bit only.
    p_demux_r4: assert property (@(posedge clk)
        (!clr_n && !wr_dis) |=> ($countones(q) <= 1 && q[$past(addr)] == $past(din)))
        else $error("demultiplexer pattern wrong");

endmodule

// File: tb/test_addr_bit_register.sv
// Bench: sweeps every address, data value and control combination and
// compares q with an arithmetic model after every clock edge.
module test_addr_bit_register;

    localparam int NBITS = 8;

    logic             clk = 1'b0;
    logic             clr_n = 1'b0;
    logic             wr_dis = 1'b1;
    logic [2:0]       addr = '0;
    logic             din = 1'b0;
    logic [NBITS-1:0] q;
    logic [NBITS-1:0] model = '0;
    int               n_checks = 0;
    int               n_fail = 0;
    bit               done = 1'b0;

    addr_bit_register #(.NBITS(NBITS)) i_addr_bit_register (
        .clk (clk), .clr_n (clr_n), .wr_dis (wr_dis),
        .addr (addr), .din (din), .q (q)
    );

    always #5 clk = ~clk;

    // Compare q with the expected value.
    task automatic check(input string req, input logic [NBITS-1:0] exp);
        n_checks++;
        if (q !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%b expected=%b", req, q, exp);
        end
    endtask

    // Drive inputs at the falling edge, update the model, then check at the next falling edge.
    task automatic step(input logic c, input logic w, input int a, input logic d, input string req);
        clr_n = c; wr_dis = w; addr = 3'(a); din = d;
        if (c && !w)       model[a] = d;
        else if (!c && w)  model = '0;
        else if (!c && !w) model = NBITS'(d) << a;
        @(negedge clk);
        check(req, model);
    endtask

    initial begin
        @(negedge clk);
        step(1'b0, 1'b1, 0, 1'b0, "R1 reset state");
        // R6 / R2: write a 1 to each address in turn.
        for (int a = 0; a < NBITS; a++) step(1'b1, 1'b0, a, 1'b1, "R6 R2 write one");
        check("R6 all set", 8'hFF);
        // R5: clear alternating bits; the others must survive.
        for (int a = 0; a < NBITS; a += 2) step(1'b1, 1'b0, a, 1'b0, "R5 partial write");
        check("R5 pattern", 8'hAA);
        // R3: sweep address and data with writing disabled.
        for (int a = 0; a < NBITS; a++) begin
            step(1'b1, 1'b1, a, 1'b1, "R3 hold");
            step(1'b1, 1'b1, a, 1'b0, "R3 hold");
        end
        check("R3 unchanged", 8'hAA);
        step(1'b0, 1'b1, 5, 1'b1, "R1 clear");
        // R4: demultiplexer over every address and both data values.
        for (int a = 0; a < NBITS; a++) begin
            step(1'b0, 1'b0, a, 1'b1, "R4 demux one");
            check("R4 onehot", 8'(1) << a);
            step(1'b0, 1'b0, a, 1'b0, "R4 demux zero");
        end
        step(1'b0, 1'b0, 6, 1'b1, "R4 demux");
        // R7: leave demux mode with writing disabled; the pattern stays.
        for (int a = 0; a < NBITS; a++) step(1'b1, 1'b1, a, 1'b0, "R7 keep");
        check("R7 keep", 8'h40);
        // Pseudo-random mixed sequence against the model.
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 2000; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0] | lf[7], lf[1] & lf[9], int'(lf[4:2]), lf[5], "R2 R3 R4 R5 mixed");
            end
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 10000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule